// File: doc/BRIEF.md
# Indexed Interrupt-Source Controller with End-of-Interrupt Handshake

This block gathers a parameterised number of raw interrupt lines and turns them into interrupt messages, one vector at a time, for an upstream controller. Software reaches it through an 8-bit index register and a 32-bit data window. The index value chooses which internal word the window reads or writes. Each source has a configuration word that holds its vector, a mask bit and trigger-mode bits. Each source also has a second word, and writing that word is one way to signal end of interrupt.

An edge-mode source sends one message for each rising edge of its line. A level-mode source sends a message while its line is high. It then waits for an end-of-interrupt before it can fire again. That end-of-interrupt comes from one of two paths: the source's own second word in the window, or a separate acknowledge register that takes a bitmask over 32 sources per word. When several sources request at once, the lowest-numbered one is offered first. A message is consumed under a valid/ready handshake.

Top module: `irq_index_ctrl`

## Requirements
- R1: After reset every source is masked, edge mode, with vector 0. Its configuration word therefore reads 0x00000001, and no message is offered even when a line rises.
- R2: With index 0x01 selected, the window reads the source count minus one in bits 23:16 and zero elsewhere. An index that maps to no word (for example 0x00, or 0xF0 with fewer than 112 sources) reads 0.
- R3: Index 0x10+2*i selects the configuration word of source i. In that word, bit 0 is the mask, bit 1 is level mode, bit 5 is the EOI request and bits 23:16 are the vector. All other bits read 0. A write of 0xFFFFFFFF reads back as 0x00FF0023.
- R4: An unmasked edge-mode source offers exactly one message for each rising edge of its line. The message appears in the cycle after the edge the line was sampled on. A line held high does not repeat the message, and a new rising edge fires again with no EOI needed.
- R5: An unmasked level-mode source with its line high offers a message. Once that message is accepted, the source offers nothing more until it receives an EOI.
- R6: Writing index 0x11+2*i with bit 31 set is an EOI for source i. The same write with bit 31 clear has no effect. If the line is still high after the EOI, the source fires again in the next cycle.
- R7: A write to acknowledge word w with bit b set is an EOI for source 32*w+b. Sources whose bits are clear, or that lie in other words, stay waiting.
- R8: A masked source offers no message. A level line held high while masked fires as soon as the mask is cleared.
- R9: Among requesting unmasked sources, the lowest-numbered wins. The same message is held while ready is low, and exactly one message is consumed per accepted handshake.
- R10: A rising edge that arrives on a masked edge-mode source is dropped. Clearing the mask later does not produce a message for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Write strobe for the index register |
| idx_wdata | input | 8 | New index value |
| win_we | input | 1 | Write strobe for the data window |
| win_wdata | input | 32 | Data written to the selected word |
| win_rdata | output | 32 | Content of the selected word |
| ack_we | input | 1 | Write strobe for the bitmask acknowledge register |
| ack_word | input | ACK_W | Acknowledge word number (source / 32) |
| ack_wdata | input | 32 | One bit per source within the word |
| irq_lines | input | NUM_SRC | Raw interrupt lines |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Upstream takes the message |
| msg_vector | output | 8 | Vector of the offered message |

## Verification
The window read data is combinational on the index register, so it is due in the cycle right after the edge that writes the index. A configuration write, an EOI or an accepted handshake changes `msg_valid` and `msg_vector` as of the same edge. A change on a line first shows in the offered message one edge after the line is driven, because the line is registered once before use. The bench drives every input and samples every output 1 ns after a rising edge, so each check reads the state left by exactly the edges it has counted.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;

   // per-source configuration, as stored
   typedef struct packed {
      logic [7:0] vector;
      logic       eoi_req;
      logic       level;
      logic       mask;
   } src_cfg_t;

   localparam logic [7:0] IDX_COUNT    = 8'h01;
   localparam logic [7:0] IDX_SRC_BASE = 8'h10;
   localparam int unsigned EOI_FLAG_BIT = 31;

   localparam src_cfg_t CFG_RESET = '{vector: 8'h00, eoi_req: 1'b0, level: 1'b0, mask: 1'b1};

   function automatic logic [31:0] cfg_to_word(src_cfg_t c);
      logic [31:0] w;
      w        = '0;
      w[0]     = c.mask;
      w[1]     = c.level;
      w[5]     = c.eoi_req;
      w[23:16] = c.vector;
      return w;
   endfunction

   function automatic src_cfg_t word_to_cfg(logic [31:0] w);
      src_cfg_t c;
      c.mask    = w[0];
      c.level   = w[1];
      c.eoi_req = w[5];
      c.vector  = w[23:16];
      return c;
   endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
   import irq_idx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        line_i,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   input  logic        eoi_i,
   input  logic        grant_i,
   output src_cfg_t    cfg_o,
   output logic        req_o,
   output logic        busy_o
);

   src_cfg_t cfg_q;
   logic     line_q;
   logic     pend_q;
   logic     busy_q;
   logic     rise;
   logic     mode_chg;

   assign rise     = line_i & ~line_q;
   assign mode_chg = cfg_we & (cfg_wdata[1] != cfg_q.level);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RESET;
         line_q <= 1'b0;
         pend_q <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         line_q <= line_i;
         if (cfg_we) begin
            cfg_q <= word_to_cfg(cfg_wdata);
         end
         // edge latch: only unmasked rising edges are kept
         if (mode_chg || cfg_q.level) begin
            pend_q <= 1'b0;
         end else begin
            pend_q <= (pend_q & ~grant_i) | (rise & ~cfg_q.mask);
         end
         // level source waits for EOI once serviced
         busy_q <= (busy_q & ~eoi_i & ~mode_chg) | (grant_i & cfg_q.level);
      end
   end

   assign req_o  = ~cfg_q.mask & (cfg_q.level ? (line_q & ~busy_q) : pend_q);
   assign cfg_o  = cfg_q;
   assign busy_o = busy_q;

endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] onehot_o,
   output logic         any_o
);

   generate
      if (N == 1) begin : g_single
         assign onehot_o = req_i;
      end else begin : g_multi
         // isolate lowest set bit
         assign onehot_o = req_i & (~req_i + N'(1));
      end
   endgenerate

   assign any_o = |req_i;

endmodule

// File: rtl/irq_index_ctrl.sv
module irq_index_ctrl
   import irq_idx_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 8,
   parameter int unsigned ACK_WORDS = (NUM_SRC + 31) / 32,
   parameter int unsigned ACK_W     = (ACK_WORDS > 1) ? $clog2(ACK_WORDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idx_we,
   input  logic [7:0]         idx_wdata,
   input  logic               win_we,
   input  logic [31:0]        win_wdata,
   output logic [31:0]        win_rdata,
   input  logic               ack_we,
   input  logic [ACK_W-1:0]   ack_word,
   input  logic [31:0]        ack_wdata,
   input  logic [NUM_SRC-1:0] irq_lines,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [7:0]         msg_vector
);

   localparam int unsigned MAX_SRC = 120;

   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_count
         $error("irq_index_ctrl: NUM_SRC must lie in 1..120");
      end
      if (ACK_W < 1) begin : g_bad_ackw
         $error("irq_index_ctrl: ACK_W must be at least 1");
      end
   endgenerate

   logic [7:0]   idx_q;
   logic [7:0]   rel;
   logic [6:0]   sel_src;
   logic         sel_hi;
   logic         in_src;

   src_cfg_t     cfg_arr [NUM_SRC];
   logic [NUM_SRC-1:0] req_vec;
   logic [NUM_SRC-1:0] busy_vec;
   logic [NUM_SRC-1:0] mask_vec;
   logic [NUM_SRC-1:0] level_vec;
   logic [NUM_SRC-1:0] eoi_vec;
   logic [NUM_SRC-1:0] pick_vec;
   logic [NUM_SRC-1:0] grant_vec;
   logic               any_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (idx_we) begin
         idx_q <= idx_wdata;
      end
   end

   assign rel     = idx_q - IDX_SRC_BASE;
   assign sel_src = rel[7:1];
   assign sel_hi  = rel[0];
   assign in_src  = (idx_q >= IDX_SRC_BASE) && (32'(sel_src) < NUM_SRC);

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         logic cfg_we_i;
         logic eoi_win_i;
         logic eoi_bm_i;

         assign cfg_we_i  = win_we & in_src & ~sel_hi & (sel_src == 7'(i));
         assign eoi_win_i = win_we & in_src & sel_hi & (sel_src == 7'(i))
                            & win_wdata[EOI_FLAG_BIT];
         assign eoi_bm_i  = ack_we & (ack_word == ACK_W'(i / 32)) & ack_wdata[i % 32];
         assign eoi_vec[i] = eoi_win_i | eoi_bm_i;

         irq_src_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (irq_lines[i]),
            .cfg_we    (cfg_we_i),
            .cfg_wdata (win_wdata),
            .eoi_i     (eoi_vec[i]),
            .grant_i   (grant_vec[i]),
            .cfg_o     (cfg_arr[i]),
            .req_o     (req_vec[i]),
            .busy_o    (busy_vec[i])
         );

         assign mask_vec[i]  = cfg_arr[i].mask;
         assign level_vec[i] = cfg_arr[i].level;
      end
   endgenerate

   irq_first_pick #(.N(NUM_SRC)) u_pick (
      .req_i    (req_vec),
      .onehot_o (pick_vec),
      .any_o    (any_req)
   );

   assign msg_valid = any_req;
   assign grant_vec = pick_vec & {NUM_SRC{msg_ready}};

   always_comb begin
      msg_vector = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (pick_vec[k]) msg_vector = cfg_arr[k].vector;
      end
   end

   always_comb begin
      win_rdata = '0;
      if (idx_q == IDX_COUNT) begin
         win_rdata[23:16] = 8'(NUM_SRC - 1);
      end else begin
         for (int k = 0; k < NUM_SRC; k++) begin
            if (in_src && !sel_hi && (sel_src == 7'(k))) win_rdata = cfg_to_word(cfg_arr[k]);
         end
      end
   end

endmodule

// File: rtl/irq_index_ctrl_chk.sv
module irq_index_ctrl_chk #(
   parameter int unsigned NUM_SRC = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msg_valid,
   input logic               msg_ready,
   input logic [NUM_SRC-1:0] req_vec,
   input logic [NUM_SRC-1:0] grant_vec,
   input logic [NUM_SRC-1:0] busy_vec,
   input logic [NUM_SRC-1:0] eoi_vec,
   input logic [NUM_SRC-1:0] mask_vec,
   input logic [NUM_SRC-1:0] level_vec
);

   // R9: a taken handshake consumes exactly one source
   p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |-> $onehot(grant_vec));

   // R9: no lower-numbered requester is passed over
   p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |-> ((req_vec & (grant_vec - 1'b1)) == '0));

   // R8: a masked source is never consumed
   p_masked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vec & mask_vec) == '0);

   // R5: a serviced level source enters the waiting state
   p_level_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant_vec & level_vec)) |=>
      ((busy_vec & $past(grant_vec & level_vec)) == $past(grant_vec & level_vec)));

   // R6 / R7: an EOI releases the waiting state
   p_eoi_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(eoi_vec & ~grant_vec)) |=> ((busy_vec & $past(eoi_vec & ~grant_vec)) == '0));

endmodule

bind irq_index_ctrl irq_index_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .req_vec   (req_vec),
   .grant_vec (grant_vec),
   .busy_vec  (busy_vec),
   .eoi_vec   (eoi_vec),
   .mask_vec  (mask_vec),
   .level_vec (level_vec)
);

// File: tb/test_irq_index_ctrl.sv
module test_irq_index_ctrl;

   localparam int unsigned NSRC  = 40;
   localparam int unsigned ACKW  = 1;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              idx_we;
   logic [7:0]        idx_wdata;
   logic              win_we;
   logic [31:0]       win_wdata;
   logic [31:0]       win_rdata;
   logic              ack_we;
   logic [ACKW-1:0]   ack_word;
   logic [31:0]       ack_wdata;
   logic [NSRC-1:0]   irq_lines;
   logic              msg_valid;
   logic              msg_ready;
   logic [7:0]        msg_vector;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_index_ctrl #(.NUM_SRC(NSRC)) i_irq_index_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_we     (idx_we),
      .idx_wdata  (idx_wdata),
      .win_we     (win_we),
      .win_wdata  (win_wdata),
      .win_rdata  (win_rdata),
      .ack_we     (ack_we),
      .ack_word   (ack_word),
      .ack_wdata  (ack_wdata),
      .irq_lines  (irq_lines),
      .msg_valid  (msg_valid),
      .msg_ready  (msg_ready),
      .msg_vector (msg_vector)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // valid and vector together
   task automatic check_msg(string tag, logic v, logic [7:0] vec);
      check({tag, " valid"}, 32'(msg_valid), 32'(v));
      if (v) check({tag, " vector"}, 32'(msg_vector), 32'(vec));
   endtask

   function automatic logic [31:0] low_word(logic [7:0] v, bit lvl, bit m);
      return {8'h00, v, 10'h000, lvl, 3'b000, lvl, m};
   endfunction

   task automatic write_idx(logic [7:0] v);
      idx_we = 1'b1; idx_wdata = v;
      tick();
      idx_we = 1'b0;
   endtask

   task automatic write_win(logic [31:0] d);
      win_we = 1'b1; win_wdata = d;
      tick();
      win_we = 1'b0;
   endtask

   task automatic set_src(int i, logic [7:0] v, bit lvl, bit m);
      write_idx(8'(8'h10 + 2 * i));
      write_win(low_word(v, lvl, m));
   endtask

   task automatic eoi_window(int i, logic [31:0] d);
      write_idx(8'(8'h11 + 2 * i));
      write_win(d);
   endtask

   task automatic eoi_mask(logic [ACKW-1:0] w, logic [31:0] bits);
      ack_we = 1'b1; ack_word = w; ack_wdata = bits;
      tick();
      ack_we = 1'b0;
   endtask

   task automatic accept();
      msg_ready = 1'b1;
      tick();
      msg_ready = 1'b0;
   endtask

   task automatic t_reset();
      check_msg("R1 no message after reset", 1'b0, 8'h00);
      write_idx(8'h10);
      check("R1 source 0 word after reset", win_rdata, 32'h0000_0001);
      write_idx(8'h5E);
      check("R1 source 39 word after reset", win_rdata, 32'h0000_0001);
      irq_lines[0] = 1'b1;
      tick(); tick();
      check_msg("R1 masked at reset ignores edge", 1'b0, 8'h00);
      irq_lines[0] = 1'b0;
      tick();
   endtask

   task automatic t_count();
      write_idx(8'h01);
      check("R2 source count field", win_rdata, 32'h0027_0000);
      write_idx(8'h00);
      check("R2 index 0x00 reads zero", win_rdata, 32'h0);
      write_idx(8'hF0);
      check("R2 unmapped index reads zero", win_rdata, 32'h0);
   endtask

   task automatic t_fields();
      write_idx(8'h1A);
      write_win(32'hFFFF_FFFF);
      check("R3 writable fields only", win_rdata, 32'h00FF_0023);
      write_win(low_word(8'hA5, 1'b0, 1'b1));
      check("R3 edge masked pattern", win_rdata, 32'h00A5_0001);
      write_idx(8'h1B);
      check("R3 second word reads zero", win_rdata, 32'h0);
   endtask

   task automatic t_edge();
      set_src(2, 8'h42, 1'b0, 1'b0);
      irq_lines[2] = 1'b1;
      check_msg("R4 not before the edge is sampled", 1'b0, 8'h00);
      tick();
      check_msg("R4 edge fires", 1'b1, 8'h42);
      accept();
      tick(); tick();
      check_msg("R4 held line does not repeat", 1'b0, 8'h00);
      irq_lines[2] = 1'b0;
      tick();
      irq_lines[2] = 1'b1;
      tick();
      check_msg("R4 new edge fires without EOI", 1'b1, 8'h42);
      accept();
      check_msg("R4 consumed", 1'b0, 8'h00);
      irq_lines[2] = 1'b0;
      tick();
   endtask

   task automatic t_level();
      set_src(4, 8'h55, 1'b1, 1'b0);
      irq_lines[4] = 1'b1;
      tick();
      check_msg("R5 level fires", 1'b1, 8'h55);
      accept();
      tick(); tick();
      check_msg("R5 waits for EOI", 1'b0, 8'h00);
      eoi_window(4, 32'h0000_0000);
      check_msg("R6 write without flag is no EOI", 1'b0, 8'h00);
      write_win(32'h8000_0000);
      check_msg("R6 window EOI refires held line", 1'b1, 8'h55);
      accept();
      set_src(36, 8'h66, 1'b1, 1'b0);
      irq_lines[36] = 1'b1;
      tick();
      check_msg("R5 second level source", 1'b1, 8'h66);
      accept();
      check_msg("R5 both waiting", 1'b0, 8'h00);
      eoi_mask(1'b1, 32'h0000_0010);
      check_msg("R7 word 1 bit 4 frees source 36 only", 1'b1, 8'h66);
      accept();
      check_msg("R7 source 4 still waiting", 1'b0, 8'h00);
      eoi_mask(1'b0, 32'h0000_0010);
      check_msg("R7 word 0 bit 4 frees source 4", 1'b1, 8'h55);
      accept();
      irq_lines[4] = 1'b0; irq_lines[36] = 1'b0;
      tick();
      eoi_mask(1'b0, 32'h0000_0010);
      eoi_mask(1'b1, 32'h0000_0010);
      tick();
      check_msg("R5 low lines stay quiet after EOI", 1'b0, 8'h00);
      set_src(4, 8'h55, 1'b1, 1'b1);
      set_src(36, 8'h66, 1'b1, 1'b1);
   endtask

   task automatic t_mask();
      set_src(6, 8'h77, 1'b1, 1'b1);
      irq_lines[6] = 1'b1;
      tick(); tick(); tick();
      check_msg("R8 masked level stays quiet", 1'b0, 8'h00);
      set_src(6, 8'h77, 1'b1, 1'b0);
      check_msg("R8 fires once unmasked", 1'b1, 8'h77);
      accept();
      irq_lines[6] = 1'b0;
      tick();
      eoi_window(6, 32'h8000_0000);
      tick();
      check_msg("R8 quiet after cleanup", 1'b0, 8'h00);
      set_src(6, 8'h77, 1'b1, 1'b1);
   endtask

   task automatic t_prio();
      set_src(1, 8'h11, 1'b0, 1'b0);
      set_src(3, 8'h33, 1'b0, 1'b0);
      set_src(7, 8'h70, 1'b0, 1'b1);
      irq_lines[1] = 1'b1; irq_lines[3] = 1'b1; irq_lines[7] = 1'b1;
      tick();
      check_msg("R9 lowest source first", 1'b1, 8'h11);
      tick(); tick();
      check_msg("R9 held while ready low", 1'b1, 8'h11);
      accept();
      check_msg("R9 next source after one accept", 1'b1, 8'h33);
      accept();
      check_msg("R10 masked edge not offered", 1'b0, 8'h00);
      set_src(7, 8'h70, 1'b0, 1'b0);
      tick();
      check_msg("R10 dropped edge stays dropped", 1'b0, 8'h00);
      irq_lines[1] = 1'b0; irq_lines[3] = 1'b0; irq_lines[7] = 1'b0;
      tick();
   endtask

   initial begin
      rst_n = 1'b0; idx_we = 1'b0; idx_wdata = '0; win_we = 1'b0; win_wdata = '0;
      ack_we = 1'b0; ack_word = '0; ack_wdata = '0; irq_lines = '0; msg_ready = 1'b0;
      tick(); tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_count();
      t_fields();
      t_edge();
      t_level();
      t_mask();
      t_prio();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1-run actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule